// File: doc/BRIEF.md
# Page Entry Permission and Update Checker

This block judges one page-table entry for one memory access, with no state and no clock. It takes the entry's 8-bit attribute byte, the kind of access, the privilege the access runs at, and two status flags. The first flag, make-executable-readable, lets execute-only pages be read. The second, supervisor-user-access, lets supervisor data accesses touch user pages. From these it reports four things: whether the entry is malformed, whether it points to a lower table level, whether the access is allowed, and the attribute byte the walker must write back when the accessed or dirty flags are still clear.

A separate path turns a failure kind into the exception cause for the access. A walker or a translation cache can then raise the right trap without its own decode table. Page-table walking and memory traffic stay in the caller. Every output is a pure function of the current inputs.

Attribute byte bit positions: 7 dirty, 6 accessed, 5 global, 4 user, 3 execute, 2 write, 1 read, 0 valid. Access code `acc_i`: 0 read, 1 write, 2 read-modify-write, 3 fetch. Privilege code `priv_i`: 0 user, 1 supervisor, 2 reserved, 3 machine. Failure code `fail_i`: 0 memory access error, 1 malformed entry, 2 permission denied, 3 misaligned large page, 4 flag update required but disabled, 5 to 7 spare.

Top module: `pte_check_top`

## Requirements
- R1: `invalid_o` is 1 exactly when valid (bit 0) is 0, or when write (bit 2) is 1 and read (bit 1) is 0.
- R2: `pointer_o` is 1 exactly when read, write and execute (bits 1, 2, 3) are all 0, whatever the other bits are.
- R3: At user privilege, `permit_o` needs user (bit 4) = 1 and also: for a read, read=1 or (execute=1 and `mxr_i`=1); for a write, write=1; for a read-modify-write, both the write and the read conditions; for a fetch, execute=1. `sum_i` has no effect at user privilege.
- R4: At supervisor privilege, a read, write or read-modify-write needs user=0 or `sum_i`=1, together with the same read/write condition as in R3.
- R5: A supervisor fetch is permitted exactly when user=0 and execute=1; `sum_i` and `mxr_i` have no effect on it.
- R6: `upd_needed_o` is 1 when accessed (bit 6) is 0, or when the access is a write or read-modify-write and dirty (bit 7) is 0.
- R7: When `upd_needed_o` is 1, `attr_upd_o` equals `attr_i` with accessed set, and dirty also set for write and read-modify-write. When it is 0, `attr_upd_o` equals `attr_i`. Bits 5..0 always pass through unchanged.
- R8: Privilege codes 2 and 3 drive `priv_err_o`=1 and `permit_o`=0. Codes 0 and 1 drive `priv_err_o`=0.
- R9: Failure code 0 gives the access-fault cause: 5 for read, 7 for write and read-modify-write, 1 for fetch.
- R10: Every failure code other than 0 (1 to 7) gives the page-fault cause: 13 for read, 15 for write and read-modify-write, 12 for fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| attr_i | input | 8 | Entry attribute byte |
| acc_i | input | 2 | Access kind code |
| priv_i | input | 2 | Effective privilege code |
| mxr_i | input | 1 | Execute-only pages readable |
| sum_i | input | 1 | Supervisor may access user pages for data |
| fail_i | input | 3 | Failure kind to classify |
| invalid_o | output | 1 | Entry is malformed |
| pointer_o | output | 1 | Entry points to next table level |
| permit_o | output | 1 | Access allowed by the entry's permissions |
| priv_err_o | output | 1 | Privilege code not handled by this checker |
| upd_needed_o | output | 1 | Accessed/dirty write-back required |
| attr_upd_o | output | 8 | Attribute byte to write back |
| cause_o | output | 5 | Exception cause for `fail_i` and `acc_i` |

## Verification
A permission verdict and an accessed/dirty update request can both arise for one entry in one evaluation. A write to a user page with accessed and dirty both clear, made from supervisor mode with `sum_i` low, gives a denial together with an update request and a rewritten byte. The bench runs every attribute byte against every access, privilege and flag setting. For each combination it judges the permit, update and write-back outputs against separately computed expectations, so a coupling between the two paths shows up as a mismatch on the side that should not have changed. The fault-cause path is swept on its own over every failure and access pairing.

// File: rtl/pte_check_pkg.sv
package pte_check_pkg;

    localparam int ATTR_W  = 8;
    localparam int CAUSE_W = 5;
    localparam int FAIL_W  = 3;

    localparam int BIT_VAL = 0;
    localparam int BIT_RD  = 1;
    localparam int BIT_WR  = 2;
    localparam int BIT_EX  = 3;
    localparam int BIT_USR = 4;
    localparam int BIT_GLB = 5;
    localparam int BIT_ACC = 6;
    localparam int BIT_DRT = 7;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_RMW   = 2'd2,
        ACC_FETCH = 2'd3
    } access_e;

    typedef enum logic [1:0] {
        PRV_USER  = 2'd0,
        PRV_SUPER = 2'd1,
        PRV_RSVD  = 2'd2,
        PRV_MACH  = 2'd3
    } priv_e;

    typedef enum logic [FAIL_W-1:0] {
        FL_MEM      = 3'd0,
        FL_MALFORM  = 3'd1,
        FL_DENIED   = 3'd2,
        FL_MISALIGN = 3'd3,
        FL_UPD_OFF  = 3'd4
    } fail_e;

    localparam logic [CAUSE_W-1:0] CS_FETCH_ACC  = 5'd1;
    localparam logic [CAUSE_W-1:0] CS_LOAD_ACC   = 5'd5;
    localparam logic [CAUSE_W-1:0] CS_STORE_ACC  = 5'd7;
    localparam logic [CAUSE_W-1:0] CS_FETCH_PAGE = 5'd12;
    localparam logic [CAUSE_W-1:0] CS_LOAD_PAGE  = 5'd13;
    localparam logic [CAUSE_W-1:0] CS_STORE_PAGE = 5'd15;

    typedef struct packed {
        logic invalid;
        logic pointer;
    } pte_kind_t;

    typedef struct packed {
        logic permit;
        logic priv_err;
    } pte_verdict_t;

    function automatic logic is_store_like(input access_e a);
        return (a == ACC_WRITE) || (a == ACC_RMW);
    endfunction

    function automatic logic [CAUSE_W-1:0] cause_of(input access_e a, input logic mem_err);
        logic [CAUSE_W-1:0] c;
        case (a)
            ACC_READ:  c = mem_err ? CS_LOAD_ACC  : CS_LOAD_PAGE;
            ACC_FETCH: c = mem_err ? CS_FETCH_ACC : CS_FETCH_PAGE;
            default:   c = mem_err ? CS_STORE_ACC : CS_STORE_PAGE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pte_attr_decode.sv
module pte_attr_decode
    import pte_check_pkg::*;
(
    input  logic      v_i,
    input  logic      r_i,
    input  logic      w_i,
    input  logic      x_i,
    output pte_kind_t kind_o
);
    always_comb begin
        kind_o.invalid = !v_i || (w_i && !r_i);
        kind_o.pointer = !(r_i || w_i || x_i);
    end
endmodule

// File: rtl/pte_perm_eval.sv
module pte_perm_eval
    import pte_check_pkg::*;
(
    input  logic         u_i,
    input  logic         r_i,
    input  logic         w_i,
    input  logic         x_i,
    input  access_e      acc_i,
    input  priv_e        priv_i,
    input  logic         mxr_i,
    input  logic         sum_i,
    output pte_verdict_t verdict_o
);
    logic rd_ok;
    logic op_ok;
    logic owner_ok;

    always_comb begin
        rd_ok = r_i || (x_i && mxr_i);
        case (acc_i)
            ACC_READ:  op_ok = rd_ok;
            ACC_WRITE: op_ok = w_i;
            ACC_RMW:   op_ok = w_i && rd_ok;
            default:   op_ok = x_i;
        endcase

        owner_ok = 1'b0;
        verdict_o.priv_err = 1'b0;
        case (priv_i)
            PRV_USER:  owner_ok = u_i;
            PRV_SUPER: owner_ok = (acc_i == ACC_FETCH) ? !u_i : (!u_i || sum_i);
            default:   verdict_o.priv_err = 1'b1;
        endcase
        verdict_o.permit = owner_ok && op_ok;
    end
endmodule

// File: rtl/pte_ad_update.sv
module pte_ad_update
    import pte_check_pkg::*;
(
    input  logic [ATTR_W-1:0] attr_i,
    input  access_e           acc_i,
    output logic              needed_o,
    output logic [ATTR_W-1:0] attr_o
);
    logic set_a;
    logic set_d;

    always_comb begin
        set_a    = !attr_i[BIT_ACC];
        set_d    = is_store_like(acc_i) && !attr_i[BIT_DRT];
        needed_o = set_a || set_d;
        attr_o   = attr_i;
        if (needed_o) begin
            attr_o[BIT_ACC] = 1'b1;
            if (set_d) attr_o[BIT_DRT] = 1'b1;
        end
    end
endmodule

// File: rtl/pte_fault_map.sv
module pte_fault_map
    import pte_check_pkg::*;
(
    input  access_e            acc_i,
    input  logic [FAIL_W-1:0]  fail_i,
    output logic [CAUSE_W-1:0] cause_o
);
    always_comb begin
        cause_o = cause_of(acc_i, fail_i == FL_MEM);
    end
endmodule

// File: rtl/pte_check_top.sv
module pte_check_top
    import pte_check_pkg::*;
(
    input  logic [7:0] attr_i,
    input  logic [1:0] acc_i,
    input  logic [1:0] priv_i,
    input  logic       mxr_i,
    input  logic       sum_i,
    input  logic [2:0] fail_i,
    output logic       invalid_o,
    output logic       pointer_o,
    output logic       permit_o,
    output logic       priv_err_o,
    output logic       upd_needed_o,
    output logic [7:0] attr_upd_o,
    output logic [4:0] cause_o
);
    access_e      acc;
    priv_e        prv;
    pte_kind_t    kind;
    pte_verdict_t verdict;

    assign acc = access_e'(acc_i);
    assign prv = priv_e'(priv_i);

    pte_attr_decode u_decode (
        .v_i    (attr_i[BIT_VAL]),
        .r_i    (attr_i[BIT_RD]),
        .w_i    (attr_i[BIT_WR]),
        .x_i    (attr_i[BIT_EX]),
        .kind_o (kind)
    );

    pte_perm_eval u_perm (
        .u_i       (attr_i[BIT_USR]),
        .r_i       (attr_i[BIT_RD]),
        .w_i       (attr_i[BIT_WR]),
        .x_i       (attr_i[BIT_EX]),
        .acc_i     (acc),
        .priv_i    (prv),
        .mxr_i     (mxr_i),
        .sum_i     (sum_i),
        .verdict_o (verdict)
    );

    pte_ad_update u_upd (
        .attr_i   (attr_i),
        .acc_i    (acc),
        .needed_o (upd_needed_o),
        .attr_o   (attr_upd_o)
    );

    pte_fault_map u_fault (
        .acc_i   (acc),
        .fail_i  (fail_i),
        .cause_o (cause_o)
    );

    assign invalid_o  = kind.invalid;
    assign pointer_o  = kind.pointer;
    assign permit_o   = verdict.permit;
    assign priv_err_o = verdict.priv_err;

    always_comb begin
        assert_err_denies_R8: assert (!(permit_o && priv_err_o));
        assert_fetch_needs_x_R3: assert (!(permit_o && acc == ACC_FETCH) || attr_i[BIT_EX]);
        assert_user_needs_u_R3: assert (!(permit_o && prv == PRV_USER) || attr_i[BIT_USR]);
        assert_low_bits_kept_R7: assert (attr_upd_o[5:0] == attr_i[5:0]);
        assert_no_upd_same_R7: assert (upd_needed_o || attr_upd_o == attr_i);
        assert_upd_sets_a_R6: assert (!upd_needed_o || attr_upd_o[BIT_ACC]);
    end
endmodule

// File: tb/test_pte_check_top.sv
module test_pte_check_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] attr;
    logic [1:0] acc;
    logic [1:0] priv;
    logic       mxr;
    logic       sum;
    logic [2:0] fail;
    logic       invalid_o, pointer_o, permit_o, priv_err_o, upd_needed_o;
    logic [7:0] attr_upd_o;
    logic [4:0] cause_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pte_check_top i_pte_check_top (
        .attr_i(attr), .acc_i(acc), .priv_i(priv), .mxr_i(mxr), .sum_i(sum),
        .fail_i(fail), .invalid_o(invalid_o), .pointer_o(pointer_o),
        .permit_o(permit_o), .priv_err_o(priv_err_o),
        .upd_needed_o(upd_needed_o), .attr_upd_o(attr_upd_o), .cause_o(cause_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s attr=%02h acc=%0d priv=%0d mxr=%0d sum=%0d fail=%0d actual=%0h expected=%0h",
                     req, attr, acc, priv, mxr, sum, fail, act, exp);
        end
    endtask

    function automatic logic exp_permit(input logic [7:0] a, input int ac, input int pv,
                                        input logic m, input logic s);
        logic rd, op, own;
        rd = a[1] | (a[3] & m);
        op = (ac == 0) ? rd : (ac == 1) ? a[2] : (ac == 2) ? (a[2] & rd) : a[3];
        if (pv == 0)      own = a[4];
        else if (pv == 1) own = (ac == 3) ? ~a[4] : (~a[4] | s);
        else              own = 1'b0;
        return own & op;
    endfunction

    function automatic logic [4:0] exp_cause(input int ac, input int fl);
        int base;
        base = (ac == 0) ? 5 : (ac == 3) ? 1 : 7;
        if (fl != 0) base = (ac == 0) ? 13 : (ac == 3) ? 12 : 15;
        return 5'(base);
    endfunction

    initial begin
        attr = '0; acc = '0; priv = '0; mxr = 1'b0; sum = 1'b0; fail = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // all-zero inputs: invalid, pointer, user read denied, update needed
        check("R1 zero", {7'd0, invalid_o}, 8'd1);
        check("R2 zero", {7'd0, pointer_o}, 8'd1);
        check("R3 zero", {7'd0, permit_o}, 8'd0);
        check("R7 zero", attr_upd_o, 8'h40);
        check("R9 zero", {3'd0, cause_o}, 8'd5);

        for (int pv = 0; pv < 4; pv++)
            for (int ac = 0; ac < 4; ac++)
                for (int fl = 0; fl < 8; fl++)
                    for (int ms = 0; ms < 4; ms++)
                        for (int a = 0; a < 256; a++) begin
                            logic [7:0] av, eu;
                            logic en, ew;
                            @(posedge clk);
                            attr = 8'(a); acc = 2'(ac); priv = 2'(pv);
                            mxr = ms[0]; sum = ms[1]; fail = 3'(fl);
                            @(negedge clk);
                            if (fl == 0) begin
                                av = 8'(a);
                                check("R1 invalid", {7'd0, invalid_o}, {7'd0, ~av[0] | (av[2] & ~av[1])});
                                check("R2 pointer", {7'd0, pointer_o}, {7'd0, ~(av[1] | av[2] | av[3])});
                                if (pv == 0)
                                    check("R3 user permit", {7'd0, permit_o}, {7'd0, exp_permit(av, ac, pv, ms[0], ms[1])});
                                else if (pv == 1 && ac != 3)
                                    check("R4 super data permit", {7'd0, permit_o}, {7'd0, exp_permit(av, ac, pv, ms[0], ms[1])});
                                else if (pv == 1)
                                    check("R5 super fetch permit", {7'd0, permit_o}, {7'd0, ~av[4] & av[3]});
                                else
                                    check("R8 denied", {7'd0, permit_o}, 8'd0);
                                check("R8 priv_err", {7'd0, priv_err_o}, {7'd0, (pv >= 2) ? 1'b1 : 1'b0});
                                ew = (ac == 1 || ac == 2) && !av[7];
                                en = !av[6] || ew;
                                check("R6 upd needed", {7'd0, upd_needed_o}, {7'd0, en});
                                eu = av;
                                if (en) begin
                                    eu[6] = 1'b1;
                                    if (ew) eu[7] = 1'b1;
                                end
                                check("R7 upd byte", attr_upd_o, eu);
                            end
                            if (a == 0 && ms == 0)
                                check(fl == 0 ? "R9 cause" : "R10 cause", {3'd0, cause_o}, {3'd0, exp_cause(ac, fl)});
                            if (ms != 0 || pv != 0) begin
                                // the outer loops continue; fail>0 only needs cause sweep
                            end
                            if (fl != 0 && a == 0) begin
                                a = 255;
                            end
                        end
        done = 1'b1;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
            done = 1'b1;
        end
    end

    initial begin
        wait (done);
        #(CLK_PERIOD);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule